// File: doc/BRIEF.md
# Event-Capture Up/Down Timer

A general-purpose 16-bit timer driven through a small word-addressed register port. Its counter counts up or down, either running free or reloading from a load register every time it expires, and it advances only on cycles when the selected clock-enable input is high. Each expiry sets a sticky timeout flag that drives the interrupt output. Software clears that flag with a write to a write-only clear register, and may at the same time restart the count.

A selectable line of a 16-bit event vector can copy the running count into a read-only capture register. The count readback register is seen through a two-stage synchronizer, so it lags the live counter by two clock cycles. If a write to the load register lands in the same cycle as an expiry, it is held back and applied one cycle later. The reload triggered by that expiry therefore uses the value that was already in place.

Register word addresses on `reg_addr_i`: 0 load, 1 count readback, 2 control, 3 clear (write-only), 4 capture, 5 status. Addresses 6 and 7 read zero.

Top module: `evt_timer`

## Requirements
- R1: After reset the load, count readback, capture and status registers read 0x0000, control reads 0x000A and `irq_o` is low.
- R2: With control bit 3 = 1 (periodic), each expiry loads the counter from the load register.
- R3: A load write in a cycle where the counter expires leaves the load register unchanged for that reload. The written value reads back from the next cycle on, unless a later write replaces it.
- R4: Address 1 returns the counter value as it was two clock edges earlier.
- R5: Control bit 1 selects the direction (1 = up, 0 = down). Counting up, an expiry happens on a step from 0xFFFF. Counting down, it happens on a step from 0x0000. In free-run mode (bit 3 = 0) the counter wraps to 0x0000 when counting up and to 0xFFFF when counting down.
- R6: The counter steps only on a cycle where control bit 0 (enable) is 1 and `clk_en_i[ctrl[6:5]]` is 1.
- R7: When control bit 12 = 1, a rising edge on `evt_i[ctrl[11:8]]` copies the count held before that edge into the capture register and sets status bit 1. Edges on other event lines, and a line held high, capture nothing.
- R8: Writing 1 to clear bit 0 loads the counter from the load register only when both control bit 7 and control bit 3 are 1. Otherwise the write leaves the counter unchanged.
- R9: Control bits 15:13, 4 and 2 always read zero, whatever is written. The clear register always reads 0x0000.
- R10: Status bit 0 is set by an expiry and drives `irq_o`. It stays set until a write of 1 to clear bit 0. If an expiry and that clear happen in the same cycle, the flag stays set. Clear bit 1 clears status bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the addressed register |
| evt_i | input | 16 | Event lines that can trigger a capture |
| clk_en_i | input | 4 | Prescaled clock-enable pulses, one per clock source |
| irq_o | output | 1 | Timeout interrupt, level |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, 16 event lines, four clock enables and two synchronizer stages. The counter can be preset through the reload-on-clear path, and random load values are biased toward both ends of the range. Together these put wrap-around, the collision of a load write with an expiry, and a clear landing in an expiry cycle within a few cycles of each other, so the random phase reaches them many times. Random control words sweep all clock selects, event selects and mode bits.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_LOAD = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_VAL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CAP  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;

  localparam logic [REG_W-1:0] CTRL_RST  = 16'h000A;
  localparam logic [REG_W-1:0] CTRL_MASK = 16'h1FEB;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_UP    = 1;
  localparam int B_PER   = 3;
  localparam int B_CS    = 5;
  localparam int B_RLD   = 7;
  localparam int B_ES    = 8;
  localparam int B_CAPEN = 12;
  localparam int CS_W    = 2;
  localparam int ES_W    = 4;
endpackage

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CLK  = 4,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             periodic_i,
  input  logic [CS_W-1:0]  clk_sel_i,
  input  logic [N_CLK-1:0] clk_en_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             clr_rld_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o,
  output logic [CNT_W-1:0] val_o
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_ok, tick;

  assign sel_ok = 32'(clk_sel_i) < N_CLK;
  assign tick   = en_i && sel_ok && clk_en_i[clk_sel_i];
  assign tmo_o  = tick && (up_i ? (cnt_q == MAXV) : (cnt_q == '0));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_rld_i)   cnt_d = load_i;
    else if (tick) begin
      if (tmo_o)     cnt_d = periodic_i ? load_i : (up_i ? '0 : MAXV);
      else           cnt_d = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  // readback synchronizer chain
  logic [CNT_W-1:0] sync_q [SYNC_N];
  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)     sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= cnt_q;
      else             sync_q[s] <= sync_q[(s > 0) ? s-1 : 0];
  end
  assign val_o = sync_q[SYNC_N-1];

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_o && periodic_i && !clr_rld_i) |=> (cnt_o == $past(load_i)));

  p_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_rld_i) |=> $stable(cnt_o));

  if (SYNC_N == 2) begin : g_lag_chk
    p_lag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      val_o == $past(cnt_o, 2));
  end
endmodule

// File: rtl/evt_timer_cap.sv
module evt_timer_cap
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_EVT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             cap_en_i,
  input  logic [ES_W-1:0]  sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             hit_o
);
  logic [N_EVT-1:0] evt_q;
  logic [CNT_W-1:0] cap_q;
  logic             sel_ok;

  assign sel_ok = 32'(sel_i) < N_EVT;
  assign hit_o  = cap_en_i && sel_ok && evt_i[sel_i] && !evt_q[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      evt_q <= '0;
      cap_q <= '0;
    end else begin
      evt_q <= evt_i;
      if (hit_o) cap_q <= cnt_i;
    end

  assign cap_o = cap_q;

  p_cap_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (cap_o == $past(cnt_i)));

  p_cap_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(cap_o));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_EVT  = 16,
  parameter int N_CLK  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic [N_CLK-1:0]  clk_en_i,
  output logic              irq_o
);
  logic [REG_W-1:0] ctrl_q, load_q, pend_d;
  logic             pend_v, tmo_flag_q, cap_flag_q;
  logic             ld_wr, ctl_wr, clr_wr, clr_rld;
  logic             tmo, cap_hit;
  logic [CNT_W-1:0] cnt, val, cap;

  assign ld_wr   = reg_we_i && (reg_addr_i == ADR_LOAD);
  assign ctl_wr  = reg_we_i && (reg_addr_i == ADR_CTRL);
  assign clr_wr  = reg_we_i && (reg_addr_i == ADR_CLR);
  assign clr_rld = clr_wr && reg_wdata_i[0] && ctrl_q[B_RLD] && ctrl_q[B_PER];

  evt_timer_cnt #(.CNT_W(CNT_W), .N_CLK(N_CLK), .SYNC_N(SYNC_N)) u_cnt (
    .clk_i,
    .rst_ni,
    .en_i       (ctrl_q[B_EN]),
    .up_i       (ctrl_q[B_UP]),
    .periodic_i (ctrl_q[B_PER]),
    .clk_sel_i  (ctrl_q[B_CS +: CS_W]),
    .clk_en_i,
    .load_i     (load_q[CNT_W-1:0]),
    .clr_rld_i  (clr_rld),
    .cnt_o      (cnt),
    .tmo_o      (tmo),
    .val_o      (val)
  );

  evt_timer_cap #(.CNT_W(CNT_W), .N_EVT(N_EVT)) u_cap (
    .clk_i,
    .rst_ni,
    .evt_i,
    .cap_en_i (ctrl_q[B_CAPEN]),
    .sel_i    (ctrl_q[B_ES +: ES_W]),
    .cnt_i    (cnt),
    .cap_o    (cap),
    .hit_o    (cap_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (ctl_wr) ctrl_q <= reg_wdata_i & CTRL_MASK;

  // load writes colliding with an expiry are parked for one cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      load_q <= '0;
      pend_d <= '0;
      pend_v <= 1'b0;
    end else if (ld_wr && tmo) begin
      pend_d <= reg_wdata_i;
      pend_v <= 1'b1;
    end else if (ld_wr) begin
      load_q <= reg_wdata_i;
      pend_v <= 1'b0;
    end else if (pend_v) begin
      load_q <= pend_d;
      pend_v <= 1'b0;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tmo_flag_q <= 1'b0;
      cap_flag_q <= 1'b0;
    end else begin
      if (tmo)                              tmo_flag_q <= 1'b1;
      else if (clr_wr && reg_wdata_i[0])    tmo_flag_q <= 1'b0;
      if (cap_hit)                          cap_flag_q <= 1'b1;
      else if (clr_wr && reg_wdata_i[1])    cap_flag_q <= 1'b0;
    end

  assign irq_o = tmo_flag_q;

  always_comb begin
    unique case (reg_addr_i)
      ADR_LOAD: reg_rdata_o = load_q;
      ADR_VAL:  reg_rdata_o = REG_W'(val);
      ADR_CTRL: reg_rdata_o = ctrl_q;
      ADR_CAP:  reg_rdata_o = REG_W'(cap);
      ADR_STAT: reg_rdata_o = REG_W'({cap_flag_q, tmo_flag_q});
      default:  reg_rdata_o = '0;
    endcase
  end

  p_defer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr && tmo) |=> (load_q == $past(load_q)));

  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(clr_wr && reg_wdata_i[0])) |=> irq_o);

  p_clr_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_rld |=> (cnt == $past(load_q[CNT_W-1:0])));
endmodule

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] ev = '0;
  logic [3:0]  ce = '0;
  logic        irq;

  always #5 clk = ~clk;

  evt_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(ev),
    .clk_en_i(ce), .irq_o(irq)
  );

  // reference model state
  logic [15:0] m_cnt = '0, m_load = '0, m_pd = '0, m_ctrl = 16'h000A;
  logic [15:0] m_cap = '0, m_s0 = '0, m_s1 = '0, m_evp = '0;
  logic        m_pv = 1'b0, m_tf = 1'b0, m_cf = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] cur_ev = '0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_s1;
      3'd2: return m_ctrl;
      3'd4: return m_cap;
      3'd5: return {14'd0, m_cf, m_tf};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_step(bit w, logic [2:0] a, logic [15:0] wd,
                            logic [15:0] e, logic [3:0] c);
    bit tick, up, per, tmo, clr, clr_rld, hit;
    logic [15:0] ncnt;
    tick = m_ctrl[0] && c[m_ctrl[6:5]];
    up   = m_ctrl[1];
    per  = m_ctrl[3];
    tmo  = tick && (up ? (m_cnt == 16'hFFFF) : (m_cnt == 16'h0000));
    clr  = w && (a == 3'd3);
    clr_rld = clr && wd[0] && m_ctrl[7] && per;
    hit  = m_ctrl[12] && e[m_ctrl[11:8]] && !m_evp[m_ctrl[11:8]];
    ncnt = m_cnt;
    if (clr_rld) ncnt = m_load;
    else if (tick) begin
      if (tmo) ncnt = per ? m_load : (up ? 16'h0000 : 16'hFFFF);
      else     ncnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
    end
    m_s1 = m_s0;
    m_s0 = m_cnt;
    if (hit) m_cap = m_cnt;
    if (tmo) m_tf = 1'b1; else if (clr && wd[0]) m_tf = 1'b0;
    if (hit) m_cf = 1'b1; else if (clr && wd[1]) m_cf = 1'b0;
    if (w && a == 3'd0 && tmo) begin m_pd = wd; m_pv = 1'b1; end
    else if (w && a == 3'd0) begin m_load = wd; m_pv = 1'b0; end
    else if (m_pv) begin m_load = m_pd; m_pv = 1'b0; end
    if (w && a == 3'd2) m_ctrl = wd & 16'h1FEB;
    m_evp = e;
    m_cnt = ncnt;
  endtask

  task automatic cyc(string tag, bit w, logic [2:0] a, logic [15:0] wd, logic [3:0] c);
    @(negedge clk);
    we = w; addr = a; wdata = wd; ce = c; ev = cur_ev;
    @(posedge clk);
    model_step(w, a, wd, cur_ev, c);
    #1;
    chk(tag, rdata, model_rd(a));
    chk("R10 irq", {15'd0, irq}, {15'd0, m_tf});
  endtask

  // counter preset through reload-on-clear
  task automatic preset(logic [15:0] v);
    cyc("R8 preset", 1, 3'd2, 16'h0088, 4'h0);
    cyc("R8 preset", 1, 3'd0, v, 4'h0);
    cyc("R8 preset", 1, 3'd3, 16'h0001, 4'h0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    string tags [8];
    void'($urandom(32'd2024));
    tags = '{"R1 load", "R4 value", "R9 ctrl", "R9 clear", "R7 capture",
             "R10 status", "R9 unmapped", "R9 unmapped"};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    cyc("R1", 0, 3'd0, 0, 0); chk("R1 load rst", rdata, 16'h0000);
    cyc("R1", 0, 3'd1, 0, 0); chk("R1 val rst", rdata, 16'h0000);
    cyc("R1", 0, 3'd2, 0, 0); chk("R1 ctrl rst", rdata, 16'h000A);
    cyc("R1", 0, 3'd4, 0, 0); chk("R1 cap rst", rdata, 16'h0000);
    cyc("R1", 0, 3'd5, 0, 0); chk("R1 stat rst", rdata, 16'h0000);
    chk("R1 irq rst", {15'd0, irq}, 16'h0000);

    // R9 reserved bits and write-only clear
    cyc("R9", 1, 3'd2, 16'hFFFF, 0); chk("R9 ctrl mask", rdata, 16'h1FEB);
    cyc("R9", 1, 3'd3, 16'hFFFF, 0); chk("R9 clear reads 0", rdata, 16'h0000);

    // R5 up free-run wrap
    preset(16'hFFFD);
    cyc("R5", 1, 3'd2, 16'h0003, 0);
    cyc("R5", 0, 3'd5, 0, 4'h1);
    cyc("R5", 0, 3'd5, 0, 4'h1); chk("R5 no expiry yet", rdata, 16'h0000);
    cyc("R5", 0, 3'd5, 0, 4'h1); chk("R5 up expiry", rdata, 16'h0001);
    chk("R10 irq set", {15'd0, irq}, 16'h0001);
    cyc("R10", 1, 3'd3, 16'h0001, 0);
    chk("R10 irq cleared", {15'd0, irq}, 16'h0000);

    // R5 down free-run wrap
    preset(16'h0002);
    cyc("R5", 1, 3'd2, 16'h0001, 0);
    repeat (3) cyc("R5", 0, 3'd5, 0, 4'h1);
    chk("R5 down expiry", rdata, 16'h0001);
    cyc("R5", 0, 3'd1, 0, 0);
    cyc("R5", 0, 3'd1, 0, 0); chk("R5 down wraps to FFFF", rdata, 16'hFFFF);

    // R2 periodic reload
    preset(16'hFFFE);
    cyc("R2", 1, 3'd2, 16'h000B, 0);
    cyc("R2", 0, 3'd1, 0, 4'h1);
    cyc("R2", 0, 3'd1, 0, 4'h1);
    cyc("R2", 0, 3'd1, 0, 0);
    cyc("R2", 0, 3'd1, 0, 0); chk("R2 reload value", rdata, 16'hFFFE);

    // R3 load write colliding with expiry
    preset(16'hFFFE);
    cyc("R3", 1, 3'd2, 16'h000B, 0);
    cyc("R3", 0, 3'd0, 0, 4'h1);
    cyc("R3", 1, 3'd0, 16'h1234, 4'h1); chk("R3 load held", rdata, 16'hFFFE);
    cyc("R3", 0, 3'd0, 0, 0);           chk("R3 load applied", rdata, 16'h1234);
    cyc("R3", 0, 3'd1, 0, 0);
    cyc("R3", 0, 3'd1, 0, 0);           chk("R3 reload used old", rdata, 16'hFFFE);

    // R4 two-cycle readback lag
    preset(16'h0100);
    cyc("R4", 1, 3'd2, 16'h0003, 0);
    repeat (3) cyc("R4", 0, 3'd1, 0, 4'h1);
    chk("R4 lag", rdata, 16'h0101);

    // R6 clock select and enable gating
    preset(16'h0010);
    cyc("R6", 1, 3'd2, 16'h0043, 0);
    repeat (4) cyc("R6", 0, 3'd1, 0, 4'b1011);
    repeat (2) cyc("R6", 0, 3'd1, 0, 4'b0100);
    cyc("R6", 0, 3'd1, 0, 0);
    cyc("R6", 0, 3'd1, 0, 0); chk("R6 selected source", rdata, 16'h0012);
    cyc("R6", 1, 3'd2, 16'h0042, 0);
    repeat (3) cyc("R6", 0, 3'd1, 0, 4'hF);
    cyc("R6", 0, 3'd1, 0, 0);
    cyc("R6", 0, 3'd1, 0, 0); chk("R6 disabled holds", rdata, 16'h0012);

    // R7 capture on selected rising edge
    preset(16'h0500);
    cyc("R7", 1, 3'd2, 16'h1503, 0);
    cyc("R7", 1, 3'd3, 16'h0003, 0);
    cur_ev = 16'h0008;
    cyc("R7", 0, 3'd4, 0, 0); chk("R7 other line ignored", rdata, 16'h0000);
    cur_ev = 16'h0028;
    cyc("R7", 0, 3'd4, 0, 0); chk("R7 captured", rdata, 16'h0500);
    cyc("R7", 0, 3'd5, 0, 4'h1); chk("R7 status bit1", rdata, 16'h0002);
    cyc("R7", 0, 3'd4, 0, 0); chk("R7 level no recapture", rdata, 16'h0500);
    cur_ev = 16'h0000;

    // R8 reload on clear needs bit 7
    preset(16'h0200);
    cyc("R8", 1, 3'd2, 16'h0009, 0);
    repeat (2) cyc("R8", 0, 3'd1, 0, 4'h1);
    cyc("R8", 1, 3'd3, 16'h0001, 0);
    cyc("R8", 0, 3'd1, 0, 0);
    cyc("R8", 0, 3'd1, 0, 0); chk("R8 clear without rld", rdata, 16'h01FE);
    cyc("R8", 1, 3'd2, 16'h0089, 0);
    cyc("R8", 1, 3'd3, 16'h0001, 0);
    cyc("R8", 0, 3'd1, 0, 0);
    cyc("R8", 0, 3'd1, 0, 0); chk("R8 clear with rld", rdata, 16'h0200);

    // R10 expiry beats clear in same cycle
    preset(16'hFFFF);
    cyc("R10", 1, 3'd2, 16'h0003, 0);
    cyc("R10", 1, 3'd3, 16'h0001, 4'h1); chk("R10 set wins", {15'd0, irq}, 16'h0001);
    cyc("R10", 1, 3'd3, 16'h0001, 0);    chk("R10 clear", {15'd0, irq}, 16'h0000);
    cyc("R10", 1, 3'd3, 16'h0002, 0);
    cyc("R10", 0, 3'd5, 0, 0);           chk("R10 status clear", rdata, 16'h0000);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit w;
      logic [2:0] a;
      logic [15:0] d;
      w = ($urandom % 10) < 3;
      a = 3'($urandom % 8);
      d = 16'($urandom);
      if (w && a == 3'd0)
        d = ($urandom % 2) ? (16'hFFFF - 16'($urandom % 8)) : 16'($urandom % 8);
      if (w && a == 3'd2) d[0] = ($urandom % 8) != 0;
      if (($urandom % 6) == 0) cur_ev[$urandom % 16] = ~cur_ev[$urandom % 16];
      cyc(tags[a], w, a, d, 4'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule